// File: doc/BRIEF.md
# Serial FIFO Pair with Level Flags and Sticky Interrupts

This block sits between the byte-level engine of a serial port and the software that feeds and drains it. It holds two queues. Software fills the transmit queue and the engine drains it. The engine fills the receive queue and software drains it. From the fill level of each queue the block derives status flags, and from those it keeps a small set of sticky interrupt request bits. Software can clear these bits, force them on, and mask them.

A width-select input sets the queue geometry. In word mode each entry is 16 bits wide and only half of the storage slots may be used. In byte mode each entry is 8 bits wide and every slot may be used. A change of that input empties both queues, and so does an explicit flush strobe. Data the engine offers to a full receive queue is discarded, and the loss is recorded as a request bit.

Top module: `ser_fifo_flags`

## Requirements
- R1: Capacity is DEPTH entries when `cfg_byte_mode` is 1 and DEPTH/2 entries when it is 0. A push to a queue at capacity is dropped, and `tx_count`/`rx_count` never exceed the capacity while the mode is unchanged.
- R2: Each queue returns entries in arrival order. A pop updates the pop data output at the clock edge that performs it, so the value is visible one cycle after the pop request. A pop on an empty queue is ignored and the pop data output holds. `eng_tx_ready` is 1 exactly when the transmit queue holds an entry.
- R3: In byte mode only bits [7:0] of a pushed value are stored, and bits [15:8] of the popped value read as zero.
- R4: `tx_not_full` is 1 exactly when the transmit count differs from the current capacity.
- R5: `tx_below_level` is 1 exactly when the transmit count is less than `cfg_tx_level`.
- R6: `rx_full` is 1 exactly when the receive count equals the capacity. A frame pushed while the queue is full is lost, and request bit 5 (receive overflow) is set on the next edge.
- R7: `rx_not_empty` is 1 exactly when the receive queue holds at least one entry.
- R8: `rx_above_level` is 1 exactly when the receive count is greater than `cfg_rx_level`.
- R9: Request bits 0..4 are set by a rising edge of, in bit order: transmit below level, transmit not full, receive above level, receive not empty, receive full. Request bits stay set until software writes a 1 to them through `irq_clr_bits` with `irq_clr_wr`. If a set cause arrives in the same cycle as the clear, the set wins.
- R10: Writing 1 to a bit of `irq_set_bits` with `irq_set_wr` sets the matching request bit on the next edge.
- R11: `irq_out` is the OR over all bits of `irq_req` AND `irq_mask`.
- R12: A pulse on `sw_flush`, or any change of `cfg_byte_mode` from its value in the previous cycle, empties both queues on the next edge. Pushes and pops in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_mode | input | 1 | 1: 8-bit entries, full depth; 0: 16-bit entries, half depth |
| cfg_tx_level | input | CW | Transmit level threshold |
| cfg_rx_level | input | CW | Receive level threshold |
| sw_flush | input | 1 | Empty both queues |
| sw_tx_wr | input | 1 | Software push into transmit queue |
| sw_tx_data | input | W | Data for the transmit push |
| sw_rx_rd | input | 1 | Software pop from receive queue |
| sw_rx_data | output | W | Last value popped from receive queue |
| eng_tx_rd | input | 1 | Engine pop from transmit queue |
| eng_tx_data | output | W | Last value popped from transmit queue |
| eng_tx_ready | output | 1 | Transmit queue holds data |
| eng_rx_wr | input | 1 | Engine push into receive queue |
| eng_rx_data | input | W | Data for the receive push |
| tx_count | output | CW | Transmit entries held |
| rx_count | output | CW | Receive entries held |
| tx_not_full | output | 1 | Transmit count differs from capacity |
| tx_below_level | output | 1 | Transmit count below threshold |
| rx_full | output | 1 | Receive count equals capacity |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_above_level | output | 1 | Receive count above threshold |
| irq_clr_wr | input | 1 | Write strobe for the clear alias |
| irq_clr_bits | input | 6 | Ones clear request bits |
| irq_set_wr | input | 1 | Write strobe for the set alias |
| irq_set_bits | input | 6 | Ones set request bits |
| irq_mask | input | 6 | Per-bit interrupt enable |
| irq_req | output | 6 | Sticky request bits |
| irq_out | output | 1 | Masked interrupt line |

## Verification
The bench targets four corner cases. The first is the capacity edge in both geometries: a design that ignored the mode bit would accept a ninth word-mode entry, or stop at eight bytes. The second is an overflowing receive push: a faulty design would overwrite the oldest entry or forget the overflow bit. The third is a mode change while the queues hold data: stale entries would survive, and at the new width their upper byte would be wrong. The fourth is the interplay of edge-set, clear and set alias: a level-sensitive design would re-raise a bit just cleared while its condition persists, and a clear-wins design would lose a cause that arrives with the clear. Long mixed traffic with random flushes and threshold changes is compared every cycle against a queue-based model.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int IRQ_N       = 6;
  localparam int IRQ_TX_LVL  = 0;
  localparam int IRQ_TX_NF   = 1;
  localparam int IRQ_RX_LVL  = 2;
  localparam int IRQ_RX_NE   = 3;
  localparam int IRQ_RX_FULL = 4;
  localparam int IRQ_RX_OVF  = 5;
  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/sff_queue.sv
module sff_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          narrow,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          dropped
);
  localparam int NB = W / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;
  logic [W-1:0]  wdata;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign do_push = push && !flush && (count < cap);
  assign do_pop  = pop  && !flush && (count != '0);
  assign dropped = push && !flush && (count >= cap);
  assign wdata   = narrow ? {{(W-NB){1'b0}}, push_data[NB-1:0]} : push_data;

  // storage: plain write port, no reset, so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      pop_data <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop) begin
        rd_ptr   <= bump(rd_ptr);
        pop_data <= mem[rd_ptr];
      end
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/sff_irq.sv
module sff_irq
  import sff_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t level,
  input  irq_vec_t pulse,
  input  logic     clr_wr,
  input  irq_vec_t clr_bits,
  input  logic     set_wr,
  input  irq_vec_t set_bits,
  input  irq_vec_t mask,
  output irq_vec_t req,
  output logic     irq_out
);
  irq_vec_t level_q, clr_eff, set_eff, req_nxt;

  assign clr_eff = clr_wr ? clr_bits : '0;
  assign set_eff = set_wr ? set_bits : '0;
  // new causes win over a clear in the same cycle
  assign req_nxt = (req & ~clr_eff) | (level & ~level_q) | pulse | set_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      req     <= '0;
    end else begin
      level_q <= level;
      req     <= req_nxt;
    end
  end

  assign irq_out = |(req & mask);
endmodule

// File: rtl/ser_fifo_flags.sv
module ser_fifo_flags
  import sff_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_byte_mode,
  input  logic [CW-1:0] cfg_tx_level,
  input  logic [CW-1:0] cfg_rx_level,
  input  logic          sw_flush,
  input  logic          sw_tx_wr,
  input  logic [W-1:0]  sw_tx_data,
  input  logic          sw_rx_rd,
  output logic [W-1:0]  sw_rx_data,
  input  logic          eng_tx_rd,
  output logic [W-1:0]  eng_tx_data,
  output logic          eng_tx_ready,
  input  logic          eng_rx_wr,
  input  logic [W-1:0]  eng_rx_data,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_not_full,
  output logic          tx_below_level,
  output logic          rx_full,
  output logic          rx_not_empty,
  output logic          rx_above_level,
  input  logic          irq_clr_wr,
  input  logic [IRQ_N-1:0] irq_clr_bits,
  input  logic          irq_set_wr,
  input  logic [IRQ_N-1:0] irq_set_bits,
  input  logic [IRQ_N-1:0] irq_mask,
  output logic [IRQ_N-1:0] irq_req,
  output logic          irq_out
);
  localparam logic [CW-1:0] CAP_BYTE = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_WORD = CW'(DEPTH / 2);

  logic          mode_q, flush;
  logic [CW-1:0] cap;
  logic          tx_drop, rx_drop;
  irq_vec_t      lvl, pls;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= cfg_byte_mode;
  end

  assign flush = sw_flush || (cfg_byte_mode != mode_q);
  assign cap   = cfg_byte_mode ? CAP_BYTE : CAP_WORD;

  sff_queue #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk(clk), .rst(rst), .flush(flush), .narrow(cfg_byte_mode), .cap(cap),
    .push(sw_tx_wr), .push_data(sw_tx_data),
    .pop(eng_tx_rd), .pop_data(eng_tx_data),
    .count(tx_count), .dropped(tx_drop)
  );

  sff_queue #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush), .narrow(cfg_byte_mode), .cap(cap),
    .push(eng_rx_wr), .push_data(eng_rx_data),
    .pop(sw_rx_rd), .pop_data(sw_rx_data),
    .count(rx_count), .dropped(rx_drop)
  );

  assign eng_tx_ready   = (tx_count != '0);
  assign tx_not_full    = (tx_count != cap);
  assign tx_below_level = (tx_count < cfg_tx_level);
  assign rx_full        = (rx_count == cap);
  assign rx_not_empty   = (rx_count != '0);
  assign rx_above_level = (rx_count > cfg_rx_level);

  always_comb begin
    lvl = '0;
    lvl[IRQ_TX_LVL]  = tx_below_level;
    lvl[IRQ_TX_NF]   = tx_not_full;
    lvl[IRQ_RX_LVL]  = rx_above_level;
    lvl[IRQ_RX_NE]   = rx_not_empty;
    lvl[IRQ_RX_FULL] = rx_full;
    pls = '0;
    pls[IRQ_RX_OVF]  = rx_drop;
  end

  sff_irq u_irq (
    .clk(clk), .rst(rst), .level(lvl), .pulse(pls),
    .clr_wr(irq_clr_wr), .clr_bits(irq_clr_bits),
    .set_wr(irq_set_wr), .set_bits(irq_set_bits),
    .mask(irq_mask), .req(irq_req), .irq_out(irq_out)
  );

  logic unused_tx_drop;
  assign unused_tx_drop = tx_drop;
endmodule

// File: rtl/sff_checker.sv
module sff_checker
  import sff_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_byte_mode,
  input logic          sw_flush,
  input logic          eng_rx_wr,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_full,
  input logic          rx_not_empty,
  input logic          irq_clr_wr,
  input logic          irq_set_wr,
  input logic [IRQ_N-1:0] irq_set_bits,
  input logic [IRQ_N-1:0] irq_mask,
  input logic [IRQ_N-1:0] irq_req,
  input logic          irq_out
);
  logic [CW-1:0] lim;
  assign lim = cfg_byte_mode ? CW'(DEPTH) : CW'(DEPTH / 2);

  p_tx_cap_r1: assert property (@(posedge clk) disable iff (rst)
    $stable(cfg_byte_mode) |-> tx_count <= lim);
  p_rx_cap_r1: assert property (@(posedge clk) disable iff (rst)
    $stable(cfg_byte_mode) |-> rx_count <= lim);
  p_drop_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_wr && rx_full && !sw_flush && $stable(cfg_byte_mode)) |=> irq_req[IRQ_RX_OVF]);
  p_full_has_data_r7: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> rx_not_empty);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !irq_clr_wr |=> (($past(irq_req) & ~irq_req) == '0));
  p_set_alias_r10: assert property (@(posedge clk) disable iff (rst)
    irq_set_wr |=> ((irq_req & $past(irq_set_bits)) == $past(irq_set_bits)));
  p_quiet_line_r11: assert property (@(posedge clk) disable iff (rst)
    ((irq_req & irq_mask) == '0) |-> !irq_out);
  p_flush_empty_r12: assert property (@(posedge clk) disable iff (rst)
    sw_flush |=> (tx_count == '0 && rx_count == '0));
endmodule

bind ser_fifo_flags sff_checker #(.DEPTH(DEPTH)) u_sff_checker (
  .clk(clk), .rst(rst), .cfg_byte_mode(cfg_byte_mode), .sw_flush(sw_flush),
  .eng_rx_wr(eng_rx_wr), .tx_count(tx_count), .rx_count(rx_count),
  .rx_full(rx_full), .rx_not_empty(rx_not_empty), .irq_clr_wr(irq_clr_wr),
  .irq_set_wr(irq_set_wr), .irq_set_bits(irq_set_bits), .irq_mask(irq_mask),
  .irq_req(irq_req), .irq_out(irq_out)
);

// File: tb/test_ser_fifo_flags.sv
module test_ser_fifo_flags;
  localparam int DEPTH = 16;
  localparam int W     = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_byte_mode = 1'b0;
  logic [CW-1:0] cfg_tx_level = '0, cfg_rx_level = '0;
  logic sw_flush = 1'b0, sw_tx_wr = 1'b0, sw_rx_rd = 1'b0;
  logic eng_tx_rd = 1'b0, eng_rx_wr = 1'b0;
  logic [W-1:0] sw_tx_data = '0, eng_rx_data = '0;
  logic irq_clr_wr = 1'b0, irq_set_wr = 1'b0;
  logic [5:0] irq_clr_bits = '0, irq_set_bits = '0, irq_mask = '0;
  logic [W-1:0] sw_rx_data, eng_tx_data;
  logic eng_tx_ready, tx_not_full, tx_below_level, rx_full, rx_not_empty, rx_above_level;
  logic [CW-1:0] tx_count, rx_count;
  logic [5:0] irq_req;
  logic irq_out;

  always #5 clk = ~clk;

  ser_fifo_flags #(.DEPTH(DEPTH), .W(W)) i_ser_fifo_flags (.*);

  int nchk = 0, nfail = 0, ncyc = 0;

  // reference model state
  logic [W-1:0] txq[$], rxq[$];
  logic [W-1:0] m_txd = '0, m_rxd = '0;
  logic [5:0]   m_req = '0, m_cond = '0;
  logic         m_bm = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int cap, txc, rxc;
    logic [5:0] cond, ev;
    logic flush, drop;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_txd = '0; m_rxd = '0; m_req = '0; m_cond = '0; m_bm = 1'b0;
      return;
    end
    cap = cfg_byte_mode ? DEPTH : DEPTH / 2;
    txc = txq.size();
    rxc = rxq.size();
    cond[0] = txc < int'(cfg_tx_level);
    cond[1] = txc != cap;
    cond[2] = rxc > int'(cfg_rx_level);
    cond[3] = rxc != 0;
    cond[4] = rxc == cap;
    cond[5] = 1'b0;
    flush = sw_flush || (cfg_byte_mode != m_bm);
    drop  = eng_rx_wr && !flush && rxc >= cap;
    ev = cond & ~m_cond;
    ev[5] = drop;
    m_req = (m_req & ~(irq_clr_wr ? irq_clr_bits : 6'h0)) | ev | (irq_set_wr ? irq_set_bits : 6'h0);
    m_cond = cond;
    if (flush) begin
      txq.delete(); rxq.delete();
    end else begin
      if (eng_tx_rd && txc > 0) m_txd = txq.pop_front();
      if (sw_tx_wr && txc < cap) txq.push_back(cfg_byte_mode ? {8'h00, sw_tx_data[7:0]} : sw_tx_data);
      if (sw_rx_rd && rxc > 0) m_rxd = rxq.pop_front();
      if (eng_rx_wr && rxc < cap) rxq.push_back(cfg_byte_mode ? {8'h00, eng_rx_data[7:0]} : eng_rx_data);
    end
    m_bm = cfg_byte_mode;
  endtask

  task automatic compare();
    int cap, txc, rxc;
    cap = cfg_byte_mode ? DEPTH : DEPTH / 2;
    txc = txq.size();
    rxc = rxq.size();
    chk("R1 tx_count", 32'(tx_count), 32'(txc));
    chk("R1 rx_count", 32'(rx_count), 32'(rxc));
    chk("R2 eng_tx_data", 32'(eng_tx_data), 32'(m_txd));
    chk("R2 sw_rx_data", 32'(sw_rx_data), 32'(m_rxd));
    chk("R2 eng_tx_ready", 32'(eng_tx_ready), 32'(txc != 0));
    chk("R4 tx_not_full", 32'(tx_not_full), 32'(txc != cap));
    chk("R5 tx_below_level", 32'(tx_below_level), 32'(txc < int'(cfg_tx_level)));
    chk("R6 rx_full", 32'(rx_full), 32'(rxc == cap));
    chk("R7 rx_not_empty", 32'(rx_not_empty), 32'(rxc != 0));
    chk("R8 rx_above_level", 32'(rx_above_level), 32'(rxc > int'(cfg_rx_level)));
    chk("R9 irq_req", 32'(irq_req), 32'(m_req));
    chk("R11 irq_out", 32'(irq_out), 32'(|(m_req & irq_mask)));
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    ncyc++;
    if (!rst) compare();
  endtask

  task automatic idle();
    sw_flush = 0; sw_tx_wr = 0; sw_rx_rd = 0; eng_tx_rd = 0; eng_rx_wr = 0;
    irq_clr_wr = 0; irq_set_wr = 0;
  endtask

  initial begin
    int limit;
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    cfg_tx_level = CW'(4);
    cfg_rx_level = CW'(5);
    tick();
    chk("R1 reset tx_count", 32'(tx_count), 32'd0);
    chk("R7 reset rx_not_empty", 32'(rx_not_empty), 32'd0);

    // word mode: fill transmit past half depth
    for (int i = 0; i < 10; i++) begin
      sw_tx_wr = 1; sw_tx_data = W'(16'h1111 * (i + 1)); tick();
    end
    idle(); tick();
    chk("R1 word cap tx_count", 32'(tx_count), 32'(DEPTH / 2));
    for (int i = 0; i < 9; i++) begin eng_tx_rd = 1; tick(); end
    idle(); tick();

    // receive overflow in word mode
    for (int i = 0; i < 10; i++) begin
      eng_rx_wr = 1; eng_rx_data = W'(16'hA000 + i); tick();
    end
    idle(); tick();
    chk("R6 overflow bit", 32'(irq_req[5]), 32'd1);
    for (int i = 0; i < 3; i++) begin sw_rx_rd = 1; tick(); end
    idle(); tick();

    // clear while some conditions persist, then set alias with mask
    irq_clr_wr = 1; irq_clr_bits = 6'h3F; tick();
    idle(); tick();
    chk("R9 cleared overflow", 32'(irq_req[5]), 32'd0);
    irq_mask = 6'h20; irq_set_wr = 1; irq_set_bits = 6'h20; tick();
    idle(); tick();
    chk("R10 set alias", 32'(irq_req[5]), 32'd1);
    chk("R11 masked line", 32'(irq_out), 32'd1);

    // switch to byte mode: flush, then narrow storage
    cfg_byte_mode = 1; tick();
    chk("R12 mode flush rx", 32'(rx_count), 32'd0);
    eng_rx_wr = 1; eng_rx_data = 16'hABCD; tick();
    idle(); sw_rx_rd = 1; tick();
    idle();
    chk("R3 upper byte zero", 32'(sw_rx_data), 32'h00CD);
    for (int i = 0; i < DEPTH + 2; i++) begin
      eng_rx_wr = 1; eng_rx_data = W'(i * 3); sw_tx_wr = 1; sw_tx_data = W'(i); tick();
    end
    idle(); tick();
    chk("R1 byte cap rx_count", 32'(rx_count), 32'(DEPTH));
    sw_flush = 1; tick();
    idle();
    chk("R12 sw flush tx", 32'(tx_count), 32'd0);
    chk("R12 sw flush rx", 32'(rx_count), 32'd0);
    tick();

    // mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      sw_tx_wr   = ($urandom % 2) == 0;
      sw_tx_data = W'($urandom);
      eng_tx_rd  = ($urandom % 5) < 2;
      eng_rx_wr  = ($urandom % 2) == 0;
      eng_rx_data = W'($urandom);
      sw_rx_rd   = ($urandom % 5) < 2;
      sw_flush   = ($urandom % 100) == 0;
      irq_clr_wr = ($urandom % 20) == 0;
      irq_clr_bits = 6'($urandom);
      irq_set_wr = ($urandom % 33) == 0;
      irq_set_bits = 6'($urandom);
      if (($urandom % 50) == 0) irq_mask = 6'($urandom);
      if (($urandom % 200) == 0) cfg_byte_mode = ~cfg_byte_mode;
      if (($urandom % 100) == 0) begin
        cfg_tx_level = CW'($urandom % (DEPTH + 1));
        cfg_rx_level = CW'($urandom % (DEPTH + 1));
      end
      tick();
    end
    idle(); tick();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule